// File: doc/BRIEF.md
# Multi-Channel Synchronous Start Controller

This block decides when each of four processing channels, and the resampler that follows them, may leave reset. Software drives it through a small register write port: a global reset register, a control register and a flush selector register. Each consumer of a sync event has a 2-bit source selector. The sources are never, the external sync pin, the internal one-shot bit, and always asserted. A consumer's hold output is the OR of the global reset and its selected sync. A channel can therefore stay held after the global reset drops, and it starts only when its sync is released.

A typical start-up runs in this order. Assert the global reset. Set the selectors to the one-shot source and raise the one-shot bit. Drop the global reset; the channels stay held. Clear the one-shot bit, and every consumer that chose that source is released on the same clock edge. The sync output pin can carry the one-shot level, so one device can release the external sync inputs of several others at once. The external sync pin is active low and passes through a two-flop synchronizer. Every device sharing the line therefore sees a release with the same fixed delay.

Top module: `sync_start_ctrl`

## Requirements
- R1: After rst_n is held low for at least one clock edge: ch_hold is 4'hF, res_hold is 1 and sync_out is 1. The global reset register reads 8'hFF, and the control and flush registers read 8'h00.
- R2: A write with wr_en high updates the register at wr_addr on that clock edge: 5 = global reset, 6 = control, 7 = flush selectors. rd_data returns that register's value combinationally. Any other address reads 8'h00, and a write to it changes no register and no output.
- R3: While the global reset register is nonzero, every ch_hold bit and res_hold are 1. The hold outputs follow a global reset register change one clock edge after the write edge.
- R4: Selector codes: 0 = never asserted, 1 = external sync, 2 = one-shot, 3 = always asserted. Control register fields: bit 0 one-shot bit, bit 1 one-shot mode, bits 3:2 output selector, bits 5:4 interpolator selector (all channels), bits 7:6 resampler selector. Flush register: bits 2i+1:2i select the flush source of channel i.
- R5: ext_sync_n is active low. A level change on it reaches the hold outputs and sync_out on the third rising clock edge after the change.
- R6: With the one-shot mode bit at 1, the one-shot source equals the one-shot bit level.
- R7: With the one-shot mode bit at 0, a write that changes the one-shot bit from 0 to 1 asserts the one-shot source for exactly one cycle. The affected hold is 1 for exactly one cycle.
- R8: ch_hold[i] is the OR of the global reset, the interpolator-selected sync and channel i's flush-selected sync. res_hold is the OR of the global reset and the resampler-selected sync. A sync that is still asserted when the global reset is released keeps its consumers held.
- R9: Consumers that select the same source are released on the same clock edge when that source is released.
- R10: sync_out is active low. It carries the inverse of the source chosen by the output selector: code 0 gives 1, code 3 gives 0.
- R11: The control and flush registers take effect while the global reset is asserted, so sync_out follows the configuration before the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read-back data, combinational |
| ext_sync_n | input | 1 | External sync, active low, asynchronous |
| sync_out | output | 1 | Sync output, active low, registered |
| ch_hold | output | 4 | Per-channel hold, active high, registered |
| res_hold | output | 1 | Resampler hold, active high, registered |

## Verification
After a register write, a hold output or sync_out changes on the edge after the write edge. The bench drives the write on a falling edge and checks one falling edge after the write task returns. Just before that, it checks that the old value is still present. A change on ext_sync_n reaches the outputs on the third rising edge, so the bench samples on the second and third falling edges after the change and expects old then new. The one-shot pulse is checked on two consecutive falling edges, which confirms a width of exactly one cycle. Simultaneous release is checked by reading all hold bits in the same sample, both before and after the release edge.

// File: rtl/sss_pkg.sv
// Shared constants, selector encoding and source selection for the
// synchronous start controller. Assumes 4 channels and 8-bit registers.
package sss_pkg;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int SEL_W  = 2;
    localparam int FL_W   = NUM_CH * SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_NEVER   = 2'd0,
        SRC_EXT     = 2'd1,
        SRC_ONESHOT = 2'd2,
        SRC_ALWAYS  = 2'd3
    } sync_src_e;

    // Return the asserted state of the source chosen by sel.
    function automatic logic pick_src(input logic [SEL_W-1:0] sel,
                                      input logic ext_act,
                                      input logic os_act);
        case (sync_src_e'(sel))
            SRC_NEVER:   pick_src = 1'b0;
            SRC_EXT:     pick_src = ext_act;
            SRC_ONESHOT: pick_src = os_act;
            default:     pick_src = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/sss_regs.sv
// Register file: global reset, control and flush selector registers,
// with combinational read-back. Writes to unmapped addresses are dropped.
// Assumes a synchronous active-low reset; the global reset register
// comes up asserted (all ones).
module sss_regs
    import sss_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GRST_ADDR  = 4'd5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 4'd6,
    parameter logic [ADDR_W-1:0] FLUSH_ADDR = 4'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              greset_act,
    output logic              os_bit,
    output logic              os_mode,
    output logic [SEL_W-1:0]  out_sel,
    output logic [SEL_W-1:0]  interp_sel,
    output logic [SEL_W-1:0]  res_sel,
    output logic [FL_W-1:0]   flush_sel
);
    logic [DATA_W-1:0] grst_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] flush_q;

    // Register writes, decoded by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grst_q  <= '1;
            ctrl_q  <= '0;
            flush_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == GRST_ADDR)  grst_q  <= wr_data;
            if (wr_addr == CTRL_ADDR)  ctrl_q  <= wr_data;
            if (wr_addr == FLUSH_ADDR) flush_q <= wr_data;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        if (rd_addr == GRST_ADDR)       rd_data = grst_q;
        else if (rd_addr == CTRL_ADDR)  rd_data = ctrl_q;
        else if (rd_addr == FLUSH_ADDR) rd_data = flush_q;
        else                            rd_data = '0;
    end

    // Field extraction.
    assign greset_act = |grst_q;
    assign os_bit     = ctrl_q[0];
    assign os_mode    = ctrl_q[1];
    assign out_sel    = ctrl_q[3:2];
    assign interp_sel = ctrl_q[5:4];
    assign res_sel    = ctrl_q[7:6];
    assign flush_sel  = flush_q[FL_W-1:0];
endmodule

// File: rtl/sss_ext_sync.sv
// Synchronizer for the active-low external sync pin. Produces an
// active-high "asserted" level after STAGES flops. Assumes that the pin
// is idle (high) during reset.
module sss_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sync_n,
    output logic ext_act
);
    logic [STAGES-1:0] chain_q;

    // Shift chain carrying the raw pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], ext_sync_n};
    end

    assign ext_act = ~chain_q[STAGES-1];
endmodule

// File: rtl/sss_oneshot.sv
// One-shot sync source. In level mode (os_mode = 1) it follows the
// one-shot bit. In pulse mode (os_mode = 0) it is high for one cycle
// after the bit goes from 0 to 1.
module sss_oneshot (
    input  logic clk,
    input  logic rst_n,
    input  logic os_bit,
    input  logic os_mode,
    output logic os_act
);
    logic os_prev_q;

    // Remember the previous bit value for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) os_prev_q <= 1'b0;
        else        os_prev_q <= os_bit;
    end

    assign os_act = os_mode ? os_bit : (os_bit & ~os_prev_q);
endmodule

// File: rtl/sss_hold_gen.sv
// Per-consumer source selection and registered hold and sync outputs.
// Holds are forced high by rst_n; sync_out idles high (active low).
module sss_hold_gen
    import sss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              greset_act,
    input  logic              ext_act,
    input  logic              os_act,
    input  logic [SEL_W-1:0]  out_sel,
    input  logic [SEL_W-1:0]  interp_sel,
    input  logic [SEL_W-1:0]  res_sel,
    input  logic [FL_W-1:0]   flush_sel,
    output logic [NUM_CH-1:0] ch_hold,
    output logic              res_hold,
    output logic              sync_out
);
    logic              interp_sync;
    logic [NUM_CH-1:0] flush_sync;

    assign interp_sync = pick_src(interp_sel, ext_act, os_act);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign flush_sync[i] = pick_src(flush_sel[i*SEL_W +: SEL_W], ext_act, os_act);

        // Channel hold: global reset, shared interpolator sync or own flush.
        always_ff @(posedge clk) begin
            if (!rst_n) ch_hold[i] <= 1'b1;
            else        ch_hold[i] <= greset_act | interp_sync | flush_sync[i];
        end
    end

    // Resampler hold: global reset or resampler sync.
    always_ff @(posedge clk) begin
        if (!rst_n) res_hold <= 1'b1;
        else        res_hold <= greset_act | pick_src(res_sel, ext_act, os_act);
    end

    // Active-low sync output driven from the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out <= 1'b1;
        else        sync_out <= ~pick_src(out_sel, ext_act, os_act);
    end
endmodule

// File: rtl/sync_start_ctrl.sv
// Top of the synchronous start controller: registers, external sync
// synchronizer, one-shot source and hold generation.
module sync_start_ctrl
    import sss_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] GRST_ADDR   = 4'd5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'd6,
    parameter logic [ADDR_W-1:0] FLUSH_ADDR  = 4'd7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        ext_sync_n,
    output logic        sync_out,
    output logic [3:0]  ch_hold,
    output logic        res_hold
);
    logic             greset_act;
    logic             os_bit;
    logic             os_mode;
    logic [SEL_W-1:0] out_sel;
    logic [SEL_W-1:0] interp_sel;
    logic [SEL_W-1:0] res_sel;
    logic [FL_W-1:0]  flush_sel;
    logic             ext_act;
    logic             os_act;

    sss_regs #(
        .GRST_ADDR (GRST_ADDR),
        .CTRL_ADDR (CTRL_ADDR),
        .FLUSH_ADDR(FLUSH_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .greset_act(greset_act),
        .os_bit    (os_bit),
        .os_mode   (os_mode),
        .out_sel   (out_sel),
        .interp_sel(interp_sel),
        .res_sel   (res_sel),
        .flush_sel (flush_sel)
    );

    sss_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sync_n(ext_sync_n),
        .ext_act   (ext_act)
    );

    sss_oneshot u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .os_bit (os_bit),
        .os_mode(os_mode),
        .os_act (os_act)
    );

    sss_hold_gen u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .greset_act(greset_act),
        .ext_act   (ext_act),
        .os_act    (os_act),
        .out_sel   (out_sel),
        .interp_sel(interp_sel),
        .res_sel   (res_sel),
        .flush_sel (flush_sel),
        .ch_hold   (ch_hold),
        .res_hold  (res_hold),
        .sync_out  (sync_out)
    );
endmodule

// File: rtl/sss_checker.sv
// Assertion checker for sync_start_ctrl, attached by bind. Relates the
// register fields and synchronized sync to the registered outputs.
module sss_checker
    import sss_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              greset_act,
    input logic              ext_act,
    input logic [SEL_W-1:0]  res_sel,
    input logic [SEL_W-1:0]  out_sel,
    input logic [FL_W-1:0]   flush_sel,
    input logic [NUM_CH-1:0] ch_hold,
    input logic              res_hold,
    input logic              sync_out
);
    // R3: global reset forces every hold on the following edge.
    a_r3_greset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        greset_act |=> (&ch_hold && res_hold));

    // R4: selector code 0 never holds the resampler outside global reset.
    a_r4_never_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!greset_act && res_sel == SRC_NEVER) |=> !res_hold);

    // R4: selector code 3 always holds.
    a_r4_always_held: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel == SRC_ALWAYS) |=> res_hold);

    // R5: synchronized external sync holds a consumer that selects it.
    a_r5_ext_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_act && res_sel == SRC_EXT) |=> res_hold);

    // R9: identical flush selectors give identical channel holds.
    a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_sel == {NUM_CH{flush_sel[SEL_W-1:0]}}) |=> (ch_hold == '0 || ch_hold == '1));

    // R10: constant output codes drive fixed levels.
    a_r10_out_always: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SRC_ALWAYS) |=> !sync_out);
    a_r10_out_never: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SRC_NEVER) |=> sync_out);
endmodule

bind sync_start_ctrl sss_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .greset_act(greset_act),
    .ext_act   (ext_act),
    .res_sel   (res_sel),
    .out_sel   (out_sel),
    .flush_sel (flush_sel),
    .ch_hold   (ch_hold),
    .res_hold  (res_hold),
    .sync_out  (sync_out)
);

// File: tb/sync_start_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for sync_start_ctrl: one task per scenario.
module sync_start_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_sync_n = 1'b1;
    logic       sync_out;
    logic [3:0] ch_hold;
    logic       res_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_start_ctrl u_sync_start_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_sync_n(ext_sync_n), .sync_out(sync_out),
        .ch_hold(ch_hold), .res_hold(res_hold)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write on a falling edge; returns on the falling edge after the write edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ch_hold", {4'h0, ch_hold}, 8'h0F);
        chk("R1 res_hold", {7'h0, res_hold}, 8'h01);
        chk("R1 sync_out", {7'h0, sync_out}, 8'h01);
        rd(4'd5, d); chk("R1 greset reg", d, 8'hFF);
        rd(4'd6, d); chk("R1 ctrl reg", d, 8'h00);
        rd(4'd7, d); chk("R1 flush reg", d, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(4'd6, 8'h5C);
        wr(4'd7, 8'hE4);
        rd(4'd6, d); chk("R2 ctrl readback", d, 8'h5C);
        rd(4'd7, d); chk("R2 flush readback", d, 8'hE4);
        wr(4'd2, 8'h33);
        rd(4'd2, d); chk("R2 unmapped reads zero", d, 8'h00);
        rd(4'd6, d); chk("R2 unmapped write no effect ctrl", d, 8'h5C);
        rd(4'd5, d); chk("R2 unmapped write no effect greset", d, 8'hFF);
        wr(4'd6, 8'h00);
        wr(4'd7, 8'h00);
    endtask

    task automatic t_greset();
        wr(4'd5, 8'h00);
        @(negedge clk);
        chk("R3 release ch_hold", {4'h0, ch_hold}, 8'h00);
        chk("R3 release res_hold", {7'h0, res_hold}, 8'h00);
        wr(4'd5, 8'hFF);
        chk("R3 not yet held", {4'h0, ch_hold}, 8'h00);
        @(negedge clk);
        chk("R3 assert ch_hold", {4'h0, ch_hold}, 8'h0F);
        chk("R3 assert res_hold", {7'h0, res_hold}, 8'h01);
        wr(4'd5, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_selectors();
        wr(4'd6, 8'hC0); @(negedge clk);
        chk("R4 code3 holds", {7'h0, res_hold}, 8'h01);
        chk("R4 ch unaffected", {4'h0, ch_hold}, 8'h00);
        wr(4'd6, 8'h40); @(negedge clk);
        chk("R4 code1 ext idle", {7'h0, res_hold}, 8'h00);
        wr(4'd6, 8'h82); @(negedge clk);
        chk("R6 level bit 0", {7'h0, res_hold}, 8'h00);
        wr(4'd6, 8'h83); @(negedge clk);
        chk("R6 level bit 1", {7'h0, res_hold}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R6 level stays", {7'h0, res_hold}, 8'h01);
        wr(4'd6, 8'h00); @(negedge clk);
        chk("R4 code0 free", {7'h0, res_hold}, 8'h00);
    endtask

    task automatic t_ext_sync();
        wr(4'd6, 8'h54);
        @(negedge clk);
        ext_sync_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R5 not before third edge", {7'h0, res_hold}, 8'h00);
        chk("R10 sync_out not yet", {7'h0, sync_out}, 8'h01);
        @(negedge clk);
        chk("R5 ext asserted res", {7'h0, res_hold}, 8'h01);
        chk("R5 ext asserted ch", {4'h0, ch_hold}, 8'h0F);
        chk("R10 sync_out follows ext", {7'h0, sync_out}, 8'h00);
        ext_sync_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R5 release not early", {7'h0, res_hold}, 8'h01);
        @(negedge clk);
        chk("R5 release res", {7'h0, res_hold}, 8'h00);
        chk("R9 release ch together", {4'h0, ch_hold}, 8'h00);
        // Channel 2 alone takes the external sync by its flush selector.
        wr(4'd6, 8'h00);
        wr(4'd7, 8'h10);
        ext_sync_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 only channel 2 held", {4'h0, ch_hold}, 8'h04);
        ext_sync_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 channel 2 free", {4'h0, ch_hold}, 8'h00);
        wr(4'd7, 8'h00);
    endtask

    task automatic t_oneshot_pulse();
        wr(4'd6, 8'h80);
        wr(4'd6, 8'h81);
        @(negedge clk);
        chk("R7 pulse high", {7'h0, res_hold}, 8'h01);
        @(negedge clk);
        chk("R7 pulse one cycle", {7'h0, res_hold}, 8'h00);
        wr(4'd6, 8'h81);
        @(negedge clk);
        chk("R7 no pulse on rewrite", {7'h0, res_hold}, 8'h00);
        wr(4'd6, 8'h00);
    endtask

    task automatic t_startup();
        wr(4'd5, 8'hFF);
        wr(4'd6, 8'h0C); @(negedge clk);
        chk("R11 sync_out set in reset", {7'h0, sync_out}, 8'h00);
        wr(4'd7, 8'hAA);
        wr(4'd6, 8'hAB);
        wr(4'd5, 8'h00);
        @(negedge clk);
        chk("R8 ch held after reset drop", {4'h0, ch_hold}, 8'h0F);
        chk("R8 res held after reset drop", {7'h0, res_hold}, 8'h01);
        chk("R10 sync_out carries one-shot", {7'h0, sync_out}, 8'h00);
        wr(4'd6, 8'hAA);
        chk("R9 all held before release", {3'h0, res_hold, ch_hold}, 8'h1F);
        @(negedge clk);
        chk("R9 all released together", {3'h0, res_hold, ch_hold}, 8'h00);
        chk("R10 sync_out released", {7'h0, sync_out}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_greset();
        t_selectors();
        t_ext_sync();
        t_oneshot_pulse();
        t_startup();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule